// File: doc/BRIEF.md
# Bit-Serial Reduction Router

This block is the combining stage of one node in a mesh of processors. The node talks to up to eight neighbours over one-bit serial links. The block lets a global reduction move through the mesh with only a couple of bits of delay per hop, because no hop waits for a whole word. Each input link arrives as a bit stream that is already aligned to the local clock, with one valid strobe per link. Each output link leaves as a bit plus a valid strobe.

A configuration is loaded in a single cycle. It selects one of three modes:

- **Broadcast:** the stream from one input direction is copied onto a set of output directions.
- **Sum:** the streams from a set of input directions, and optionally the node's own operand bit, are added. Operands arrive least significant bit first. The sum is sent on the output set. The carry is kept from one word to the next, so several words form one wide integer. A fixed number of extra bits then flush the remaining carry.
- **Max:** operands arrive most significant bit first. The largest operand of each word is forwarded as it is being decided.

The block waits, and emits nothing, until every selected input shows a valid bit. This keeps the streams in step.

Top module: `serial_reduce_node`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `out_vld` and `out_bit` are 0. They stay 0 until a configuration is loaded.
- R2: With `cfg_mode`=0 (broadcast) and a one-hot input mask, each accepted input bit appears one cycle later. It appears on `out_bit` of every direction in the output mask, with `out_vld` set on exactly those directions. Directions outside the output mask carry 0 on both `out_vld` and `out_bit`.
- R3: With `cfg_mode`=1 (sum), output bit i (counted from 0, in emission order) is bit i of the integer sum of the selected operands. Operands arrive least significant bit first.
- R4: In sum mode, a run of `cfg_words` words of WORD_BITS bits each is one operand of `cfg_words`×WORD_BITS bits. The carry passes across word boundaries.
- R5: After the last input bit in sum mode, exactly CARRY_W = ceil(log2(NDIR+2)) further output bits are emitted, with no input valid needed. They carry the high bits of the sum.
- R6: When `cfg_local_en` is 1, `local_bit` is taken as one more operand in sum and max modes. When `cfg_local_en` is 0, `local_bit` has no effect.
- R7: With `cfg_mode`=2 (max), each word arrives most significant bit first. The output for each word is the largest of the selected operands' words, emitted most significant bit first.
- R8: An input bit position is accepted only in a cycle where `in_vld` is 1 on every direction in the input mask. No output is valid in the cycle after a stalled cycle.
- R9: `done` pulses for one cycle, together with the last output bit. `busy` is then 0. A `cfg_load` while `busy` is 1 is ignored.
- R10: The bits and valids of input directions outside the input mask have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load configuration and start (taken only when idle) |
| cfg_mode | input | 2 | 0 broadcast, 1 sum, 2 max |
| cfg_in_mask | input | NDIR | Input directions taking part |
| cfg_out_mask | input | NDIR | Output directions to drive |
| cfg_local_en | input | 1 | Include the node's own operand |
| cfg_words | input | WCNT_W | Number of words in the operation (at least 1) |
| in_bit | input | NDIR | Serial data bit per input direction |
| in_vld | input | NDIR | Valid strobe per input direction |
| local_bit | input | 1 | Node's own operand bit, sampled with each accepted position |
| out_bit | output | NDIR | Serial data bit per output direction |
| out_vld | output | NDIR | Valid strobe per output direction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse with the final output bit |

## Verification
The assertions assume that `cfg_words` is at least 1 whenever a load is accepted. In broadcast mode they assume the input mask is one-hot. They also assume `local_bit` is stable at each accepted position.

The stimulus keeps to these assumptions:
- It loads only nonzero word counts and one-hot broadcast masks.
- It changes inputs only on the falling edge.
- It puts random bits and valids on the unused directions, to show they have no effect.
- It withholds a single selected valid to create stalls.
- It pulses `cfg_load` in the middle of a run, to show that the load is ignored.

// File: rtl/serial_reduce_pkg.sv
package serial_reduce_pkg;

  typedef enum logic [1:0] {
    MODE_BCAST = 2'd0,
    MODE_SUM   = 2'd1,
    MODE_MAX   = 2'd2
  } mode_e;

  // number of set bits in a vector of up to 32 lanes
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += 32'(v[i]);
    return n;
  endfunction

  // one column of a serial add: lane count plus carry in
  function automatic int unsigned column_total(input logic [31:0] lanes,
                                               input int unsigned carry_in);
    return ones32(lanes) + carry_in;
  endfunction

  // keep only candidates showing a 1, unless none does
  function automatic logic [31:0] narrow_cands(input logic [31:0] cand,
                                               input logic [31:0] bits);
    logic [31:0] hit;
    hit = cand & bits;
    return (|hit) ? hit : cand;
  endfunction

endpackage

// File: rtl/sr_sequencer.sv
module sr_sequencer #(
  parameter int WORD_BITS  = 8,
  parameter int WCNT_W     = 4,
  parameter int DRAIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WCNT_W-1:0] words,
  input  logic              drain_en,
  input  logic              aligned,
  output logic              busy,
  output logic              step,
  output logic              first_bit,
  output logic              draining,
  output logic              finish
);
  localparam int BIT_W  = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
  localparam int DCNT_W = $clog2(DRAIN_BITS) + 1;
  localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(WORD_BITS - 1);
  localparam logic [DCNT_W-1:0] DRN_LAST = DCNT_W'(DRAIN_BITS - 1);

  logic              run_q, drain_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WCNT_W-1:0] word_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic              run_step, last_run;

  assign run_step  = run_q & aligned;
  assign last_run  = run_step & (bit_q == BIT_LAST) & (word_q == words - WCNT_W'(1));
  assign step      = run_step | drain_q;
  assign busy      = run_q | drain_q;
  assign first_bit = (bit_q == '0);
  assign draining  = drain_q;
  assign finish    = (last_run & ~drain_en) | (drain_q & (dcnt_q == DRN_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      drain_q <= 1'b0;
      bit_q   <= '0;
      word_q  <= '0;
      dcnt_q  <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      drain_q <= 1'b0;
      bit_q   <= '0;
      word_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      if (run_step) begin
        if (bit_q == BIT_LAST) begin
          bit_q <= '0;
          if (last_run) begin
            run_q   <= 1'b0;
            drain_q <= drain_en;
            dcnt_q  <= '0;
          end else begin
            word_q <= word_q + WCNT_W'(1);
          end
        end else begin
          bit_q <= bit_q + BIT_W'(1);
        end
      end
      if (drain_q) begin
        if (dcnt_q == DRN_LAST) drain_q <= 1'b0;
        else                    dcnt_q  <= dcnt_q + DCNT_W'(1);
      end
    end
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && drain_q)); // R5
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy); // R9
endmodule

// File: rtl/sr_sum_lane.sv
module sr_sum_lane
  import serial_reduce_pkg::*;
#(
  parameter int NIN     = 9,
  parameter int CARRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [NIN-1:0]     bits,
  output logic               sum_bit,
  output logic [CARRY_W-1:0] carry_o
);
  logic [CARRY_W-1:0] carry_q;
  int unsigned        col;

  always_comb begin
    col     = column_total(32'(bits), 32'(carry_q));
    sum_bit = col[0];
  end
  assign carry_o = carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) carry_q <= '0;
    else if (step)       carry_q <= CARRY_W'(col >> 1);
  end

  AST_CARRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(carry_q) < NIN); // R4
endmodule

// File: rtl/sr_max_lane.sv
module sr_max_lane
  import serial_reduce_pkg::*;
#(
  parameter int NIN = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           first_bit,
  input  logic [NIN-1:0] init_mask,
  input  logic [NIN-1:0] bits,
  output logic           max_bit
);
  logic [NIN-1:0] cand_q, cand_use, cand_next;

  assign cand_use  = first_bit ? init_mask : cand_q;
  assign max_bit   = |(cand_use & bits);
  assign cand_next = NIN'(narrow_cands(32'(cand_use), 32'(bits)));

  always_ff @(posedge clk) begin
    if (!rst_n)    cand_q <= '0;
    else if (step) cand_q <= cand_next;
  end

  AST_CAND_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((cand_q & ~$past(cand_use)) == '0)); // R7
  AST_CAND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (|cand_use)) |=> (|cand_q)); // R7
endmodule

// File: rtl/serial_reduce_node.sv
module serial_reduce_node
  import serial_reduce_pkg::*;
#(
  parameter int NDIR      = 8,
  parameter int WORD_BITS = 8,
  parameter int WCNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic [NDIR-1:0]   cfg_in_mask,
  input  logic [NDIR-1:0]   cfg_out_mask,
  input  logic              cfg_local_en,
  input  logic [WCNT_W-1:0] cfg_words,
  input  logic [NDIR-1:0]   in_bit,
  input  logic [NDIR-1:0]   in_vld,
  input  logic              local_bit,
  output logic [NDIR-1:0]   out_bit,
  output logic [NDIR-1:0]   out_vld,
  output logic              busy,
  output logic              done
);
  localparam int NIN     = NDIR + 1;
  localparam int CARRY_W = $clog2(NDIR + 2);

  mode_e             mode_q;
  logic [NDIR-1:0]   imask_q, omask_q;
  logic              loc_q;
  logic [WCNT_W-1:0] words_q;

  logic start, aligned, step, first_bit, draining, finish, drain_en;
  logic [NIN-1:0] lanes, init_mask;
  logic bcast_bit, sum_bit, max_bit, sel_bit;
  logic [CARRY_W-1:0] carry;
  logic [NDIR-1:0] obit_q, ovld_q;
  logic done_q;

  assign start    = cfg_load & ~busy;
  assign aligned  = &(in_vld | ~imask_q);
  assign drain_en = (mode_q == MODE_SUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_BCAST;
      imask_q <= '0;
      omask_q <= '0;
      loc_q   <= 1'b0;
      words_q <= '0;
    end else if (start) begin
      mode_q  <= mode_e'(cfg_mode);
      imask_q <= cfg_in_mask;
      omask_q <= cfg_out_mask;
      loc_q   <= cfg_local_en;
      words_q <= cfg_words;
    end
  end

  sr_sequencer #(.WORD_BITS(WORD_BITS), .WCNT_W(WCNT_W), .DRAIN_BITS(CARRY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .words(words_q),
    .drain_en(drain_en), .aligned(aligned), .busy(busy), .step(step),
    .first_bit(first_bit), .draining(draining), .finish(finish)
  );

  assign lanes     = draining ? '0 : {loc_q & local_bit, in_bit & imask_q};
  assign init_mask = {loc_q, imask_q};
  assign bcast_bit = |(in_bit & imask_q);

  sr_sum_lane #(.NIN(NIN), .CARRY_W(CARRY_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(step),
    .bits(lanes), .sum_bit(sum_bit), .carry_o(carry)
  );

  sr_max_lane #(.NIN(NIN)) u_max (
    .clk(clk), .rst_n(rst_n), .step(step), .first_bit(first_bit),
    .init_mask(init_mask), .bits(lanes), .max_bit(max_bit)
  );

  always_comb begin
    case (mode_q)
      MODE_SUM: sel_bit = sum_bit;
      MODE_MAX: sel_bit = max_bit;
      default:  sel_bit = bcast_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obit_q <= '0;
      ovld_q <= '0;
      done_q <= 1'b0;
    end else begin
      obit_q <= step ? ({NDIR{sel_bit}} & omask_q) : '0;
      ovld_q <= step ? omask_q : '0;
      done_q <= finish;
    end
  end

  assign out_bit = obit_q;
  assign out_vld = ovld_q;
  assign done    = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (out_vld == '0 && !done)); // R1
  AST_OUT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld & ~omask_q) == '0) && ((out_bit & ~out_vld) == '0)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !draining && !aligned) |=> (out_vld == '0)); // R8
  AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MODE_SUM) |-> (carry == '0)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
endmodule

// File: tb/tb_serial_reduce_node.sv
module tb_serial_reduce_node;
  localparam int NDIR = 8;
  localparam int W    = 8;
  localparam int WC   = 4;
  localparam int CW   = 4; // ceil(log2(NDIR+2)) per R5

  typedef struct {
    logic  b;
    logic  last;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_local_en = 0, local_bit = 0;
  logic [1:0] cfg_mode = 0;
  logic [NDIR-1:0] cfg_in_mask = 0, cfg_out_mask = 0, in_bit = 0, in_vld = 0;
  logic [WC-1:0] cfg_words = 0;
  logic [NDIR-1:0] out_bit, out_vld;
  logic busy, done;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic [NDIR-1:0] cur_omask = 0;
  longint opnd [0:NDIR];

  always #4 clk = ~clk;

  serial_reduce_node #(.NDIR(NDIR), .WORD_BITS(W), .WCNT_W(WC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_in_mask(cfg_in_mask), .cfg_out_mask(cfg_out_mask),
    .cfg_local_en(cfg_local_en), .cfg_words(cfg_words), .in_bit(in_bit),
    .in_vld(in_vld), .local_bit(local_bit), .out_bit(out_bit),
    .out_vld(out_vld), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every valid output
  always @(negedge clk) begin
    if (rst_n) begin
      if (|out_vld) begin
        if (q.size() == 0) begin
          check("R2 unexpected output", longint'(out_vld), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " out_vld"}, longint'(out_vld), longint'(cur_omask));
          check({e.tag, " out_bit"}, longint'(out_bit), e.b ? longint'(cur_omask) : 0);
          check({e.tag, " done"}, longint'(done), longint'(e.last));
        end
      end else if (done) begin
        check("R9 done without output", 1, 0);
      end
    end
  end

  task automatic run_op(input string tag, input int mode, input logic [NDIR-1:0] im,
                        input logic [NDIR-1:0] om, input logic le, input int words,
                        input bit stall, input bit garbage);
    int nb, total_bits;
    longint sum, m, wv, wmask, opmask;
    exp_t e;
    nb = words * W;
    wmask  = (longint'(1) << W) - 1;
    opmask = (longint'(1) << nb) - 1;
    total_bits = (mode == 1) ? nb + CW : nb;
    e.tag = tag;
    if (mode == 1) begin
      sum = 0;
      for (int d = 0; d < NDIR; d++) if (im[d]) sum += opnd[d] & opmask;
      if (le) sum += opnd[NDIR] & opmask;
      for (int i = 0; i < total_bits; i++) begin
        e.b = sum[i]; e.last = (i == total_bits - 1); q.push_back(e);
      end
    end else if (mode == 2) begin
      for (int k = 0; k < words; k++) begin
        m = 0;
        for (int d = 0; d <= NDIR; d++) begin
          if ((d < NDIR && im[d]) || (d == NDIR && le)) begin
            wv = (opnd[d] >> (k * W)) & wmask;
            if (wv > m) m = wv;
          end
        end
        for (int b = W - 1; b >= 0; b--) begin
          e.b = m[b]; e.last = (k == words - 1) && (b == 0); q.push_back(e);
        end
      end
    end else begin
      for (int i = 0; i < nb; i++) begin
        e.b = 1'b0;
        for (int d = 0; d < NDIR; d++) if (im[d]) e.b = opnd[d][i];
        e.last = (i == nb - 1); q.push_back(e);
      end
    end

    @(negedge clk);
    cfg_mode = 2'(mode); cfg_in_mask = im; cfg_out_mask = om;
    cfg_local_en = le; cfg_words = WC'(words); cfg_load = 1'b1;
    cur_omask = om;
    @(negedge clk);
    cfg_load = 1'b0;
    for (int j = 0; j < nb; j++) begin
      int pos;
      pos = (mode == 2) ? (j / W) * W + (W - 1 - j % W) : j;
      if (stall && (j % 3 == 1)) begin
        logic [NDIR-1:0] lowest;
        lowest = im & (~im + 1'b1);
        in_vld = im & ~lowest;
        in_bit = $urandom();
        @(negedge clk);
        check("R8 no output after stall", longint'(out_vld), 0);
      end
      for (int d = 0; d < NDIR; d++) begin
        in_bit[d] = im[d] ? opnd[d][pos] : (garbage ? 1'($urandom()) : 1'b0);
        in_vld[d] = im[d] ? 1'b1 : (garbage ? 1'($urandom()) : 1'b0);
      end
      local_bit = opnd[NDIR][pos];
      if (garbage && j == 2) begin // R9: a load while busy is ignored
        cfg_load = 1'b1; cfg_mode = 2'd2; cfg_out_mask = ~om; cfg_in_mask = '1;
      end else begin
        cfg_load = 1'b0;
      end
      @(negedge clk);
    end
    cfg_load = 1'b0; in_vld = '0; in_bit = '0; local_bit = 1'b0;
    repeat (CW + 3) @(negedge clk);
    check({tag, " all outputs seen"}, longint'(q.size()), 0);
    check("R9 busy low after operation", longint'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", longint'(busy), 0);
    check("R1 out_vld at reset", longint'(out_vld), 0);
    check("R1 done at reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out_bit idle", longint'(out_bit), 0);

    // R2 broadcast from direction 2 to three outputs
    for (int d = 0; d <= NDIR; d++) opnd[d] = 0;
    opnd[2] = 64'hA5C3;
    run_op("R2 broadcast", 0, 8'b0000_0100, 8'b1001_0001, 1'b0, 2, 1'b0, 1'b0);

    // R3 three-way single-word sum
    opnd[0] = 64'hFF; opnd[3] = 64'h81; opnd[7] = 64'h7E;
    run_op("R3 sum", 1, 8'b1000_1001, 8'b0000_0010, 1'b0, 1, 1'b0, 1'b0);

    // R4 R5 R6 all eight plus local, all ones, three words: largest carry
    for (int d = 0; d <= NDIR; d++) opnd[d] = 64'hFFFFFF;
    run_op("R4 R5 R6 wide sum", 1, 8'hFF, 8'h40, 1'b1, 3, 1'b0, 1'b0);

    // R8 sum with stalls
    for (int d = 0; d <= NDIR; d++) opnd[d] = 64'h1234 * (d + 3);
    run_op("R8 stalled sum", 1, 8'b0110_0110, 8'b0000_1000, 1'b0, 2, 1'b1, 1'b0);

    // R7 max, ties and per-word winners
    opnd[1] = 64'h5A3C; opnd[4] = 64'h5A41; opnd[5] = 64'h1F3C; opnd[6] = 64'h5A00;
    run_op("R7 max", 2, 8'b0111_0010, 8'b0010_0000, 1'b0, 2, 1'b0, 1'b0);

    // R6 R7 local operand wins max
    opnd[NDIR] = 64'hC0FE;
    run_op("R6 R7 max local", 2, 8'b0111_0010, 8'b0000_0001, 1'b1, 2, 1'b1, 1'b0);

    // R10 R9 garbage on unused inputs, load while busy
    opnd[0] = 64'h00FF00; opnd[2] = 64'h0F0F0F;
    run_op("R10 R9 sum ignore unmasked", 1, 8'b0000_0101, 8'b1100_0000, 1'b0, 3, 1'b0, 1'b1);

    // R6 local disabled: local_bit must not matter
    opnd[NDIR] = 64'hFFFF;
    run_op("R6 local off", 1, 8'b0000_0101, 8'b0000_0011, 1'b0, 2, 1'b0, 1'b1);

    // R2 R10 broadcast with garbage and stalls
    opnd[6] = 64'h3C96;
    run_op("R2 R10 broadcast noisy", 0, 8'b0100_0000, 8'b0011_1110, 1'b0, 2, 1'b1, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule